// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 words held in flip-flops. A 6-bit stack pointer always addresses the current top word. A push moves the pointer up by one, with wrap from 63 to 0, and then writes the incoming word at the new pointer. A pop reads the word at the pointer into a registered output and then moves the pointer down by one. So the first word pushed goes to address 1 and the 64th goes to address 0. A pointer value of zero therefore means either empty or full, and two status flags tell the two cases apart.

Each request that the stack cannot carry out is refused. This covers a push while full, a pop while empty, and a push and pop in the same cycle. The pointer, the stored words, the flags and the output word all stay as they were, and an error output goes high for exactly one cycle. Surrounding control logic uses the flags to avoid such requests and uses the error pulse to trap any that slip through.

Top module: `reg_stack`

## Requirements
- R1: After synchronous reset, `sp` is 0, `empty` is 1, `full` is 0, `err` is 0 and `pop_data` is 0.
- R2: An accepted push (push_req=1, pop_req=0, full=0) makes `sp` one higher (63 wraps to 0) in the next cycle and clears `empty`.
- R3: The push that brings `sp` to 0 sets `full`. This is the 64th push counted from empty, so the first word sits at address 1 and the 64th at address 0. `full` and `empty` are never both 1.
- R4: An accepted pop (pop_req=1, push_req=0, empty=0) places the word at the current `sp` on `pop_data` in the next cycle, makes `sp` one lower (0 wraps to 63) and clears `full`.
- R5: The pop that brings `sp` to 0 sets `empty`.
- R6: Words come out of accepted pops in the reverse order of the accepted pushes, including across a completely full stack.
- R7: A push while `full`=1 raises `err` in the next cycle. It leaves `sp`, `full`, `empty`, `pop_data` and the stored words unchanged.
- R8: A pop while `empty`=1 raises `err` in the next cycle. It leaves `sp`, the flags and `pop_data` unchanged.
- R9: A push and a pop requested in the same cycle raise `err` in the next cycle and change neither `sp`, the flags, `pop_data` nor the stored words.
- R10: `err` is high for one cycle per refused request. It is low in the cycle after an accepted or idle cycle. `pop_data` holds its value when no pop is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to push `push_data` |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DATA_W (8) | Word written on an accepted push |
| pop_data | output | DATA_W (8) | Registered word from the last accepted pop |
| sp | output | PTR_W (6) | Stack pointer, address of the top word |
| full | output | 1 | Stack holds 64 words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
Every result of this block is registered, so the pointer, both flags, the popped word and the error pulse all change at the first rising edge after the request is presented. The bench drives each request on a falling edge and releases it on the next falling edge. It checks the outputs at that second falling edge, which is exactly one edge after the request. A separate idle cycle after each refused request confirms that `err` drops again and that nothing else has moved.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Operation chosen for one cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BAD  = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic full;
        logic empty;
    } stk_flags_t;

    localparam stk_flags_t FLAGS_RESET = '{full: 1'b0, empty: 1'b1};

    // Classify the request pair against the current flags
    function automatic stk_op_e classify(input logic push, input logic pop,
                                         input stk_flags_t fl);
        stk_op_e op;
        op = OP_IDLE;
        if (push && pop)          op = OP_BAD;
        else if (push && fl.full) op = OP_BAD;
        else if (pop && fl.empty) op = OP_BAD;
        else if (push)            op = OP_PUSH;
        else if (pop)             op = OP_POP;
        return op;
    endfunction

endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push_req,
    input  logic       pop_req,
    input  stk_flags_t flags,
    output stk_op_e    op,
    output logic       err_q
);

    always_comb begin
        op = classify(push_req, pop_req, flags);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= (op == OP_BAD);
    end

endmodule

// File: rtl/rstk_ptr.sv
module rstk_ptr
    import rstk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] sp_q,
    output stk_flags_t       flags_q
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [PTR_W-1:0] sp_up;
    logic [PTR_W-1:0] sp_dn;

    always_comb begin
        sp_up = sp_q + STEP;
        sp_dn = sp_q - STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            flags_q <= FLAGS_RESET;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    sp_q          <= sp_up;
                    flags_q.full  <= (sp_up == '0);
                    flags_q.empty <= 1'b0;
                end
                OP_POP: begin
                    sp_q          <= sp_dn;
                    flags_q.empty <= (sp_dn == '0);
                    flags_q.full  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rstk_store.sv
module rstk_store
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  stk_op_e           op,
    input  logic [PTR_W-1:0]  sp,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << PTR_W;
    localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

    logic [DATA_W-1:0] words [DEPTH];
    logic [PTR_W-1:0]  wr_addr;

    always_comb begin
        wr_addr = sp + STEP;
    end

    // Word array: no reset, written only on an accepted push
    always_ff @(posedge clk) begin
        if (op == OP_PUSH) words[wr_addr] <= wr_data;
    end

    // Registered read port, updated only on an accepted pop
    always_ff @(posedge clk) begin
        if (rst)               rd_q <= '0;
        else if (op == OP_POP) rd_q <= words[sp];
    end

endmodule

// File: rtl/reg_stack.sv
module reg_stack
    import rstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTR_W-1:0]  sp,
    output logic              full,
    output logic              empty,
    output logic              err
);

    stk_op_e    op;
    stk_flags_t flags;

    rstk_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .flags    (flags),
        .op       (op),
        .err_q    (err)
    );

    rstk_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .sp_q    (sp),
        .flags_q (flags)
    );

    rstk_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .sp      (sp),
        .wr_data (push_data),
        .rd_q    (pop_data)
    );

    assign full  = flags.full;
    assign empty = flags.empty;

endmodule

// File: rtl/reg_stack_chk.sv
module reg_stack_chk #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              push_req,
    input logic              pop_req,
    input logic [DATA_W-1:0] pop_data,
    input logic [PTR_W-1:0]  sp,
    input logic              full,
    input logic              empty,
    input logic              err
);

    logic push_ok, pop_ok, bad;

    always_comb begin
        push_ok = push_req && !pop_req && !full;
        pop_ok  = pop_req && !push_req && !empty;
        bad     = (push_req && pop_req) || (push_req && full) || (pop_req && empty);
    end

    // R2: accepted push moves pointer up and clears empty
    p_push_moves_r2: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> (sp == $past(sp) + PTR_W'(1)) && !empty);

    // R3: push landing on zero sets full
    p_full_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (push_ok && sp == {PTR_W{1'b1}}) |=> full);

    // R3: the two flags never coexist
    p_flags_apart_r3: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R4: accepted pop moves pointer down and clears full
    p_pop_moves_r4: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> (sp == $past(sp) - PTR_W'(1)) && !full);

    // R5: pop landing on zero sets empty
    p_empty_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && sp == PTR_W'(1)) |=> empty);

    // R7, R8, R9: refused request pulses err and freezes state
    p_refused_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        bad |=> err && $stable(sp) && $stable(full) && $stable(empty) && $stable(pop_data));

    // R10: no err after a cycle without a refused request
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        !bad |=> !err);

    // R10: output word holds without an accepted pop
    p_data_holds_r10: assert property (@(posedge clk) disable iff (rst)
        !pop_ok |=> $stable(pop_data));

endmodule

bind reg_stack reg_stack_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .pop_data (pop_data),
    .sp       (sp),
    .full     (full),
    .empty    (empty),
    .err      (err)
);

// File: tb/reg_stack_test.sv
module reg_stack_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 6;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              push_req = 1'b0;
    logic              pop_req = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic [DATA_W-1:0] pop_data;
    logic [PTR_W-1:0]  sp;
    logic              full, empty, err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_stack #(.DATA_W(DATA_W), .PTR_W(PTR_W)) uut (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pop_data(pop_data), .sp(sp),
        .full(full), .empty(empty), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One request cycle; outputs are checked one edge later at the next falling edge
    task automatic step(input logic psh, input logic pp, input logic [DATA_W-1:0] d);
        @(negedge clk);
        push_req = psh; pop_req = pp; push_data = d;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] pat(input int i);
        return DATA_W'(i * 5 + 7);
    endfunction

    task automatic t_reset();
        check("R1 sp", sp, 0);
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 err", err, 0);
        check("R1 pop_data", pop_data, 0);
    endtask

    task automatic t_pop_empty();
        step(1'b0, 1'b1, '0);
        check("R8 err", err, 1);
        check("R8 sp", sp, 0);
        check("R8 empty", empty, 1);
        check("R8 pop_data", pop_data, 0);
        step(1'b0, 1'b0, '0);
        check("R10 err low", err, 0);
    endtask

    task automatic t_push_few();
        step(1'b1, 1'b0, 8'hA1);
        check("R2 sp", sp, 1);
        check("R2 empty", empty, 0);
        check("R10 err", err, 0);
        step(1'b1, 1'b0, 8'hB2);
        check("R2 sp", sp, 2);
        step(1'b1, 1'b0, 8'hC3);
        check("R2 sp", sp, 3);
        check("R3 full", full, 0);
    endtask

    task automatic t_both();
        step(1'b1, 1'b1, 8'hEE);
        check("R9 err", err, 1);
        check("R9 sp", sp, 3);
        check("R9 empty", empty, 0);
        check("R9 pop_data", pop_data, 0);
        step(1'b0, 1'b0, '0);
        check("R10 err low", err, 0);
    endtask

    task automatic t_pop_few();
        step(1'b0, 1'b1, '0);
        check("R4 data (R9 no write)", pop_data, 8'hC3);
        check("R4 sp", sp, 2);
        step(1'b0, 1'b0, '0);
        check("R10 hold", pop_data, 8'hC3);
        step(1'b0, 1'b1, '0);
        check("R6 data", pop_data, 8'hB2);
        step(1'b0, 1'b1, '0);
        check("R6 data", pop_data, 8'hA1);
        check("R5 sp", sp, 0);
        check("R5 empty", empty, 1);
    endtask

    task automatic t_fill();
        for (int i = 1; i <= DEPTH; i++) begin
            step(1'b1, 1'b0, pat(i));
            check("R2 sp fill", sp, i % DEPTH);
            check("R3 full", full, (i == DEPTH) ? 1 : 0);
        end
        check("R3 empty", empty, 0);
        step(1'b1, 1'b0, 8'h55);
        check("R7 err", err, 1);
        check("R7 sp", sp, 0);
        check("R7 full", full, 1);
        check("R7 empty", empty, 0);
        step(1'b0, 1'b0, '0);
        check("R10 err low", err, 0);
        step(1'b0, 1'b1, '0);
        check("R3 word at 0 (R7 no write)", pop_data, pat(DEPTH));
        check("R4 sp wrap", sp, DEPTH - 1);
        check("R4 full", full, 0);
        step(1'b1, 1'b0, pat(DEPTH));
        check("R3 full again", full, 1);
        for (int j = DEPTH; j >= 1; j--) begin
            step(1'b0, 1'b1, '0);
            check("R6 drain", pop_data, pat(j));
            check("R4 sp drain", sp, j - 1);
            check("R5 empty", empty, (j == 1) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pop_empty();
        t_push_few();
        t_both();
        t_pop_few();
        t_fill();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule